// File: doc/BRIEF.md
# Dual Data Pointer Address Unit

This block keeps the two 16-bit data pointers of an 8051-style core, one 8-bit extension byte for each, a one-bit pointer-select register, and two bytes that sit above the R0/R1 index when the core reaches external data through a register. Software reaches every one of these bytes through a plain SFR read/write port. The core's decoder sends one request per instruction that uses a pointer. For an external-data move the block forms a 24-bit data address. For a code read or an indexed jump it forms a 16-bit code address. For an increment or an immediate load it updates the selected pointer and sends nothing out.

The request side and the address side are valid/ready streams. The address side has one register stage. A request is taken in any cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or the consumer takes its beat in that cycle. While `addr_valid` is high and `addr_ready` is low, the beat stays frozen and new requests wait. Increment and load requests follow the same handshake, so pointer updates stay in request order with the address beats around them. The bus cycle and instruction decoding belong to the core.

Top module: `ddp_unit`

## Requirements
- R1: After reset every pointer byte, every extension byte, the select register and both register-index extension bytes read 0x00, so pointer 0 is selected, and `addr_valid` is low.
- R2: The select register (SFR 0x86) keeps only bit 0. Bits 7:1 always read as zero, and the register changes only through an SFR write. Value 0 selects pointer 0 and value 1 selects pointer 1.
- R3: A pointer-based external data request (op 0) produces the beat {ext, high, low} of the selected pointer, with `addr_code` = 0.
- R4: A register-based external data request (op 1) produces the beat {top byte (SFR 0xA2), middle byte (SFR 0xA1), `req_ri`}, with `addr_code` = 0.
- R5: A code read (op 2) or an indexed jump (op 3) produces {0x00, (selected pointer + `req_acc`) mod 65536} with `addr_code` = 1. Extension bytes never appear in it.
- R6: An increment (op 4) adds one to the full 16-bit selected pointer. The carry goes from the low byte into the high byte, and 0xFFFF wraps to 0x0000 with the extension byte left unchanged.
- R7: An immediate load (op 5) writes `req_imm` into the selected pointer only and leaves the other pointer unchanged. Neither op 4 nor op 5 produces an output beat.
- R8: Every register is readable through `sfr_rdata` and writable through the SFR port. The map is: pointer 0 low/high 0x82/0x83, pointer 1 low/high 0x84/0x85, extensions 0x93/0x95, middle 0xA1, top 0xA2. Any other address reads 0x00.
- R9: If a pointer update and an SFR write to the high or low byte of the same pointer happen in the same cycle, the update wins. A same-cycle write to that pointer's extension byte still takes effect. Every address uses the register values from before the cycle's writes.
- R10: `req_ready` = !`addr_valid` || `addr_ready`. A stalled beat holds its address and code flag until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr_en | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for write and read |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data at `sfr_addr` (combinational) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_op | input | 3 | Operation code 0..5 as listed in the requirements |
| req_ri | input | 8 | R0/R1 value for op 1 |
| req_acc | input | 8 | Accumulator for ops 2 and 3 |
| req_imm | input | 16 | Immediate for op 5 |
| addr_valid | output | 1 | Address beat present |
| addr_ready | input | 1 | Consumer takes the beat |
| addr_out | output | 24 | Formed address |
| addr_code | output | 1 | 1 for a code address, 0 for external data |

## Verification
On every cycle the assertions check the handshake rules: ready whenever the stage is empty, and a frozen beat while stalled. They also check that code beats carry a zero top byte, that a register-based request puts `req_ri` in the low byte, that increments and loads produce no beat and leave the extension bytes alone, and that the select register moves only on a write. The bench's scenarios show the actual arithmetic: the carry across the byte boundary, wrap-around at 0xFFFF and in the code sum, which pointer a load reaches, the same-cycle priority between a write and an update, and the readback of the whole register map. A behavioural model compares all outputs on every clock under mixed random traffic with random back-pressure.

// File: rtl/ddp_pkg.sv
package ddp_pkg;
  localparam int BYTE_W = 8;
  localparam int NPTR   = 2;
  localparam int AOUT_W = 3 * BYTE_W;

  typedef enum logic [2:0] {
    OP_XDATA_PTR = 3'd0,
    OP_XDATA_REG = 3'd1,
    OP_CODE_RD   = 3'd2,
    OP_JUMP      = 3'd3,
    OP_INC       = 3'd4,
    OP_LOAD      = 3'd5
  } ddp_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] ext;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } ptr_t;

  typedef struct packed {
    logic              code;
    logic [AOUT_W-1:0] addr;
  } beat_t;
endpackage

// File: rtl/ddp_sfr_regs.sv
module ddp_sfr_regs
  import ddp_pkg::*;
#(
  parameter logic [7:0] A_LO0  = 8'h82,
  parameter logic [7:0] A_HI0  = 8'h83,
  parameter logic [7:0] A_LO1  = 8'h84,
  parameter logic [7:0] A_HI1  = 8'h85,
  parameter logic [7:0] A_SEL  = 8'h86,
  parameter logic [7:0] A_EXT0 = 8'h93,
  parameter logic [7:0] A_EXT1 = 8'h95,
  parameter logic [7:0] A_MID  = 8'hA1,
  parameter logic [7:0] A_TOP  = 8'hA2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              addr,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic [BYTE_W-1:0]       rd_data,
  input  logic                    upd_en,
  input  logic [2*BYTE_W-1:0]     upd_val,
  output ptr_t                    ptr_o [NPTR],
  output logic                    sel_o,
  output logic [BYTE_W-1:0]       mid_o,
  output logic [BYTE_W-1:0]       top_o
);
  localparam logic [7:0] LO_A  [NPTR] = '{A_LO0, A_LO1};
  localparam logic [7:0] HI_A  [NPTR] = '{A_HI0, A_HI1};
  localparam logic [7:0] EXT_A [NPTR] = '{A_EXT0, A_EXT1};

  logic              sel_q;
  logic [BYTE_W-1:0] mid_q, top_q;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    ptr_t r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
      end else begin
        if (upd_en && (sel_q == 1'(i))) begin
          {r_q.hi, r_q.lo} <= upd_val;
        end else begin
          if (wr_en && addr == LO_A[i]) r_q.lo <= wr_data;
          if (wr_en && addr == HI_A[i]) r_q.hi <= wr_data;
        end
        if (wr_en && addr == EXT_A[i]) r_q.ext <= wr_data;
      end
    end
    assign ptr_o[i] = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      mid_q <= '0;
      top_q <= '0;
    end else if (wr_en) begin
      if (addr == A_SEL) sel_q <= wr_data[0];
      if (addr == A_MID) mid_q <= wr_data;
      if (addr == A_TOP) top_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (addr == LO_A[i])  rd_data = ptr_o[i].lo;
      if (addr == HI_A[i])  rd_data = ptr_o[i].hi;
      if (addr == EXT_A[i]) rd_data = ptr_o[i].ext;
    end
    if (addr == A_SEL) rd_data = {{(BYTE_W-1){1'b0}}, sel_q};
    if (addr == A_MID) rd_data = mid_q;
    if (addr == A_TOP) rd_data = top_q;
  end

  assign sel_o = sel_q;
  assign mid_o = mid_q;
  assign top_o = top_q;
endmodule

// File: rtl/ddp_addr_gen.sv
module ddp_addr_gen
  import ddp_pkg::*;
(
  input  ddp_op_e               op,
  input  logic [BYTE_W-1:0]     ri,
  input  logic [BYTE_W-1:0]     acc,
  input  logic [2*BYTE_W-1:0]   imm,
  input  ptr_t                  ptr_i [NPTR],
  input  logic                  sel,
  input  logic [BYTE_W-1:0]     mid,
  input  logic [BYTE_W-1:0]     top,
  output logic                  emit,
  output beat_t                 beat,
  output logic                  upd,
  output logic [2*BYTE_W-1:0]   upd_val
);
  ptr_t                cur;
  logic [2*BYTE_W-1:0] cur16;
  logic [2*BYTE_W-1:0] idx_sum;

  assign cur     = ptr_i[sel];
  assign cur16   = {cur.hi, cur.lo};
  assign idx_sum = cur16 + {{BYTE_W{1'b0}}, acc};

  always_comb begin
    emit    = 1'b0;
    upd     = 1'b0;
    upd_val = cur16;
    beat    = '0;
    unique case (op)
      OP_XDATA_PTR: begin
        emit      = 1'b1;
        beat.addr = {cur.ext, cur.hi, cur.lo};
      end
      OP_XDATA_REG: begin
        emit      = 1'b1;
        beat.addr = {top, mid, ri};
      end
      OP_CODE_RD, OP_JUMP: begin
        emit      = 1'b1;
        beat.code = 1'b1;
        beat.addr = {{BYTE_W{1'b0}}, idx_sum};
      end
      OP_INC: begin
        upd     = 1'b1;
        upd_val = cur16 + 1'b1;
      end
      OP_LOAD: begin
        upd     = 1'b1;
        upd_val = imm;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddp_out_stage.sv
module ddp_out_stage #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_take,
  input  logic         in_emit,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_take && in_emit;
      if (in_take && in_emit) out_data <= in_data;
    end
  end
endmodule

// File: rtl/ddp_unit.sv
module ddp_unit
  import ddp_pkg::*;
#(
  parameter logic [7:0] A_LO0  = 8'h82,
  parameter logic [7:0] A_HI0  = 8'h83,
  parameter logic [7:0] A_LO1  = 8'h84,
  parameter logic [7:0] A_HI1  = 8'h85,
  parameter logic [7:0] A_SEL  = 8'h86,
  parameter logic [7:0] A_EXT0 = 8'h93,
  parameter logic [7:0] A_EXT1 = 8'h95,
  parameter logic [7:0] A_MID  = 8'hA1,
  parameter logic [7:0] A_TOP  = 8'hA2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sfr_wr_en,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [7:0]  req_ri,
  input  logic [7:0]  req_acc,
  input  logic [15:0] req_imm,
  output logic        addr_valid,
  input  logic        addr_ready,
  output logic [23:0] addr_out,
  output logic        addr_code
);
  localparam int BEAT_W = $bits(beat_t);

  ptr_t              ptr_w [NPTR];
  logic              sel_q;
  logic [BYTE_W-1:0] mid_w, top_w;
  logic              emit_w, upd_w, take_w;
  logic [15:0]       upd_val_w;
  beat_t             beat_w, beat_q;
  logic [7:0]        ext0_q, ext1_q;

  assign take_w = req_valid && req_ready;
  assign ext0_q = ptr_w[0].ext;
  assign ext1_q = ptr_w[1].ext;

  ddp_sfr_regs #(
    .A_LO0(A_LO0), .A_HI0(A_HI0), .A_LO1(A_LO1), .A_HI1(A_HI1),
    .A_SEL(A_SEL), .A_EXT0(A_EXT0), .A_EXT1(A_EXT1),
    .A_MID(A_MID), .A_TOP(A_TOP)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sfr_wr_en),
    .addr    (sfr_addr),
    .wr_data (sfr_wdata),
    .rd_data (sfr_rdata),
    .upd_en  (take_w && upd_w),
    .upd_val (upd_val_w),
    .ptr_o   (ptr_w),
    .sel_o   (sel_q),
    .mid_o   (mid_w),
    .top_o   (top_w)
  );

  ddp_addr_gen u_gen (
    .op      (ddp_op_e'(req_op)),
    .ri      (req_ri),
    .acc     (req_acc),
    .imm     (req_imm),
    .ptr_i   (ptr_w),
    .sel     (sel_q),
    .mid     (mid_w),
    .top     (top_w),
    .emit    (emit_w),
    .beat    (beat_w),
    .upd     (upd_w),
    .upd_val (upd_val_w)
  );

  ddp_out_stage #(.W(BEAT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_take   (take_w),
    .in_emit   (emit_w),
    .in_data   (beat_w),
    .in_ready  (req_ready),
    .out_valid (addr_valid),
    .out_ready (addr_ready),
    .out_data  (beat_q)
  );

  assign addr_out  = beat_q.addr;
  assign addr_code = beat_q.code;
endmodule

// File: rtl/ddp_unit_chk.sv
module ddp_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sfr_wr_en,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_op,
  input logic [7:0]  req_ri,
  input logic        addr_valid,
  input logic        addr_ready,
  input logic [23:0] addr_out,
  input logic        addr_code,
  input logic        sel_q,
  input logic [7:0]  ext0_q,
  input logic [7:0]  ext1_q
);
  logic take;
  assign take = req_valid && req_ready;

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> req_ready); // R10
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_out) && $stable(addr_code)); // R10
  AST_CODE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_code |-> addr_out[23:16] == 8'h00); // R5
  AST_REG_INDEX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op == 3'd1 |=> addr_valid && !addr_code && addr_out[7:0] == $past(req_ri)); // R4
  AST_LOAD_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    take && (req_op == 3'd4 || req_op == 3'd5) |=> !addr_valid); // R7
  AST_INC_KEEPS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op == 3'd4 && !sfr_wr_en |=> $stable(ext0_q) && $stable(ext1_q)); // R6
  AST_SEL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_wr_en |=> $stable(sel_q)); // R2
endmodule

bind ddp_unit ddp_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sfr_wr_en  (sfr_wr_en),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .req_ri     (req_ri),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .addr_out   (addr_out),
  .addr_code  (addr_code),
  .sel_q      (sel_q),
  .ext0_q     (ext0_q),
  .ext1_q     (ext1_q)
);

// File: tb/ddp_unit_tb.sv
module ddp_unit_tb;
  localparam logic [7:0] A_LO0 = 8'h82, A_HI0 = 8'h83, A_LO1 = 8'h84, A_HI1 = 8'h85;
  localparam logic [7:0] A_SEL = 8'h86, A_EXT0 = 8'h93, A_EXT1 = 8'h95;
  localparam logic [7:0] A_MID = 8'hA1, A_TOP = 8'hA2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_wr_en = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [7:0]  req_ri = 8'h00;
  logic [7:0]  req_acc = 8'h00;
  logic [15:0] req_imm = 16'h0000;
  logic        addr_valid;
  logic        addr_ready = 1'b1;
  logic [23:0] addr_out;
  logic        addr_code;

  always #2.5 clk = ~clk;

  ddp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_wr_en(sfr_wr_en), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_ri(req_ri), .req_acc(req_acc),
    .req_imm(req_imm), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_out(addr_out), .addr_code(addr_code)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [7:0]  m_lo [2];
  logic [7:0]  m_hi [2];
  logic [7:0]  m_ext [2];
  logic        m_sel;
  logic [7:0]  m_mid, m_top;
  logic        m_valid;
  logic [23:0] m_addr;
  logic        m_code;
  logic        m_took;

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(logic [7:0] a);
    case (a)
      A_LO0:  return m_lo[0];
      A_HI0:  return m_hi[0];
      A_LO1:  return m_lo[1];
      A_HI1:  return m_hi[1];
      A_EXT0: return m_ext[0];
      A_EXT1: return m_ext[1];
      A_SEL:  return {7'd0, m_sel};
      A_MID:  return m_mid;
      A_TOP:  return m_top;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 2; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_ext[i] = 0;
    end
    m_sel = 0; m_mid = 0; m_top = 0; m_valid = 0; m_addr = 0; m_code = 0;
  endtask

  task automatic compare();
    check("sfr_rdata", 32'(sfr_rdata), 32'(m_read(sfr_addr)));
    check("req_ready", 32'(req_ready), 32'(!m_valid || addr_ready));
    check("addr_valid", 32'(addr_valid), 32'(m_valid));
    if (m_valid) begin
      check("addr_out", 32'(addr_out), 32'(m_addr));
      check("addr_code", 32'(addr_code), 32'(m_code));
    end
  endtask

  // one clock: next state from current model state and current inputs
  task automatic tick();
    logic [7:0]  n_lo [2];
    logic [7:0]  n_hi [2];
    logic [7:0]  n_ext [2];
    logic        n_sel, n_valid, n_code, rdy, take;
    logic [7:0]  n_mid, n_top;
    logic [23:0] n_addr;
    int          s;
    int          cur;
    s = int'(m_sel);
    cur = {m_hi[s], m_lo[s]};
    for (int i = 0; i < 2; i++) begin
      n_lo[i] = m_lo[i]; n_hi[i] = m_hi[i]; n_ext[i] = m_ext[i];
    end
    n_sel = m_sel; n_mid = m_mid; n_top = m_top;
    n_valid = m_valid; n_addr = m_addr; n_code = m_code;
    if (sfr_wr_en) begin
      case (sfr_addr)
        A_LO0:  n_lo[0] = sfr_wdata;
        A_HI0:  n_hi[0] = sfr_wdata;
        A_LO1:  n_lo[1] = sfr_wdata;
        A_HI1:  n_hi[1] = sfr_wdata;
        A_EXT0: n_ext[0] = sfr_wdata;
        A_EXT1: n_ext[1] = sfr_wdata;
        A_SEL:  n_sel = sfr_wdata[0];
        A_MID:  n_mid = sfr_wdata;
        A_TOP:  n_top = sfr_wdata;
        default: ;
      endcase
    end
    rdy  = !m_valid || addr_ready;
    take = req_valid && rdy;
    if (rdy) n_valid = 0;
    if (take) begin
      case (req_op)
        3'd0: begin n_valid = 1; n_code = 0; n_addr = {m_ext[s], m_hi[s], m_lo[s]}; end
        3'd1: begin n_valid = 1; n_code = 0; n_addr = {m_top, m_mid, req_ri}; end
        3'd2, 3'd3: begin
          n_valid = 1; n_code = 1; n_addr = 24'((cur + int'(req_acc)) % 65536);
        end
        3'd4: begin n_hi[s] = 8'(((cur + 1) % 65536) / 256); n_lo[s] = 8'((cur + 1) % 256); end
        3'd5: begin n_hi[s] = req_imm[15:8]; n_lo[s] = req_imm[7:0]; end
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < 2; i++) begin
      m_lo[i] = n_lo[i]; m_hi[i] = n_hi[i]; m_ext[i] = n_ext[i];
    end
    m_sel = n_sel; m_mid = n_mid; m_top = n_top;
    m_valid = n_valid; m_addr = n_addr; m_code = n_code; m_took = take;
    compare();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    sfr_wr_en = 1; sfr_addr = a; sfr_wdata = d;
    tick();
    sfr_wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a);
    sfr_addr = a;
    tick();
  endtask

  task automatic issue(logic [2:0] op, logic [7:0] ri, logic [7:0] acc, logic [15:0] imm);
    req_valid = 1; req_op = op; req_ri = ri; req_acc = acc; req_imm = imm;
    do tick(); while (!m_took);
    req_valid = 0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    // R1: reset state over the whole map
    cur_req = "R1";
    compare();
    check("addr_valid after reset", 32'(addr_valid), 32'h0);
    foreach (m_lo[i]) begin
      rd(i == 0 ? A_LO0 : A_LO1);
      rd(i == 0 ? A_HI0 : A_HI1);
      rd(i == 0 ? A_EXT0 : A_EXT1);
    end
    rd(A_SEL); rd(A_MID); rd(A_TOP);

    // R8: write and read back the map, plus an unmapped address
    cur_req = "R8";
    wr(A_LO0, 8'h34); wr(A_HI0, 8'h12); wr(A_EXT0, 8'h5A);
    wr(A_LO1, 8'hCD); wr(A_HI1, 8'hAB); wr(A_EXT1, 8'h7E);
    wr(A_MID, 8'h66); wr(A_TOP, 8'h99);
    rd(A_HI0);  check("hi0 readback", 32'(sfr_rdata), 32'h12);
    rd(A_EXT1); check("ext1 readback", 32'(sfr_rdata), 32'h7E);
    rd(8'h10);  check("unmapped read", 32'(sfr_rdata), 32'h00);

    // R2: select keeps bit 0 only
    cur_req = "R2";
    wr(A_SEL, 8'hFE); rd(A_SEL); check("sel bits", 32'(sfr_rdata), 32'h00);
    wr(A_SEL, 8'hFF); rd(A_SEL); check("sel bits", 32'(sfr_rdata), 32'h01);

    // R3: pointer-based data address from each pointer
    cur_req = "R3";
    issue(3'd0, 8'h00, 8'h00, 16'h0);
    check("ptr1 data addr", 32'(addr_out), 32'h7EABCD);
    wr(A_SEL, 8'h00);
    issue(3'd0, 8'h00, 8'h00, 16'h0);
    check("ptr0 data addr", 32'(addr_out), 32'h5A1234);
    check("ptr0 data code", 32'(addr_code), 32'h0);

    // R4: register-based data address
    cur_req = "R4";
    issue(3'd1, 8'h4C, 8'h00, 16'h0);
    check("reg data addr", 32'(addr_out), 32'h99664C);

    // R5: code and jump sums wrap, no extension byte
    cur_req = "R5";
    wr(A_LO0, 8'hF0); wr(A_HI0, 8'hFF);
    issue(3'd2, 8'h00, 8'h20, 16'h0);
    check("code wrap", 32'(addr_out), 32'h000010);
    check("code flag", 32'(addr_code), 32'h1);
    issue(3'd3, 8'h00, 8'h05, 16'h0);
    check("jump addr", 32'(addr_out), 32'h00FFF5);

    // R6: increment carry and wrap
    cur_req = "R6";
    wr(A_LO0, 8'hFF); wr(A_HI0, 8'h12);
    issue(3'd4, 8'h00, 8'h00, 16'h0);
    rd(A_HI0); check("inc carry hi", 32'(sfr_rdata), 32'h13);
    rd(A_LO0); check("inc carry lo", 32'(sfr_rdata), 32'h00);
    wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF);
    issue(3'd4, 8'h00, 8'h00, 16'h0);
    rd(A_HI0);  check("inc wrap hi", 32'(sfr_rdata), 32'h00);
    rd(A_EXT0); check("inc wrap ext", 32'(sfr_rdata), 32'h5A);

    // R7: load reaches only the selected pointer, no beat
    cur_req = "R7";
    wr(A_SEL, 8'h01);
    issue(3'd5, 8'h00, 8'h00, 16'hBEEF);
    check("load no beat", 32'(addr_valid), 32'h0);
    rd(A_LO1); check("load ptr1 lo", 32'(sfr_rdata), 32'hEF);
    rd(A_HI0); check("ptr0 untouched", 32'(sfr_rdata), 32'h00);

    // R9: same-cycle update against SFR writes
    cur_req = "R9";
    sfr_wr_en = 1; sfr_addr = A_LO1; sfr_wdata = 8'h11;
    issue(3'd4, 8'h00, 8'h00, 16'h0);
    sfr_wr_en = 0;
    rd(A_LO1); check("update beats write", 32'(sfr_rdata), 32'hF0);
    sfr_wr_en = 1; sfr_addr = A_EXT1; sfr_wdata = 8'h3C;
    issue(3'd0, 8'h00, 8'h00, 16'h0);
    sfr_wr_en = 0;
    check("old ext used", 32'(addr_out), 32'h7EBEF0);
    rd(A_EXT1); check("ext write kept", 32'(sfr_rdata), 32'h3C);

    // R10: back-pressure
    cur_req = "R10";
    addr_ready = 0;
    issue(3'd1, 8'h01, 8'h00, 16'h0);
    req_valid = 1; req_op = 3'd1; req_ri = 8'h02;
    repeat (4) tick();
    check("stall ready low", 32'(req_ready), 32'h0);
    check("stall addr held", 32'(addr_out), 32'h996601);
    addr_ready = 1;
    do tick(); while (!m_took);
    req_valid = 0;
    check("next beat", 32'(addr_out), 32'h996602);

    // mixed traffic with random back-pressure
    for (int n = 0; n < 600; n++) begin
      int pick;
      pick = $urandom_range(0, 8);
      req_valid  = ($urandom_range(0, 2) != 0);
      req_op     = 3'($urandom_range(0, 5));
      req_ri     = 8'($urandom);
      req_acc    = 8'($urandom);
      req_imm    = 16'($urandom);
      addr_ready = ($urandom_range(0, 3) != 0);
      sfr_wr_en  = ($urandom_range(0, 3) == 0);
      case (pick)
        0: sfr_addr = A_LO0;  1: sfr_addr = A_HI0;  2: sfr_addr = A_LO1;
        3: sfr_addr = A_HI1;  4: sfr_addr = A_SEL;  5: sfr_addr = A_EXT0;
        6: sfr_addr = A_EXT1; 7: sfr_addr = A_MID;  default: sfr_addr = A_TOP;
      endcase
      sfr_wdata = 8'($urandom);
      tick();
    end
    req_valid = 0; sfr_wr_en = 0; addr_ready = 1;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule